// File: doc/BRIEF.md
# Microprogram Sequencer with Control-Field Expansion

This block is the control unit of a multicycle processor built around a microcode store. A microaddress register selects one microinstruction per cycle. Each stored word holds a handful of symbolic fields: ALU function, operand sources, register-file action, memory action, PC action and a sequencing choice. A decoder turns these fields into the individual control lines that steer the datapath.

The sequencing field picks the next microaddress. It can step to the following word, jump back to the fetch entry, or dispatch through one of two tables indexed by the instruction opcode. The first table routes each instruction class to its first execution step after decode. The second table separates loads from stores once the effective address is formed. The ALU zero flag comes in as an input so that a branch can gate its PC load within the same cycle.

The microprogram holds ten words. The fetch entry is at address 0. The other entries are: decode (1), address form (2), load access (3), load writeback (4), store access (5), register-op execute (6), register-op writeback (7), branch compare (8) and jump (9). Any unused address returns to fetch.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `uaddr` is 0. The control lines then carry the fetch word: memory read with PC addressing, IR load, ALU add of PC and constant 4, and an unconditional PC load from the ALU.
- R2: A word whose sequencing code is 2'b11 makes `uaddr` one greater on the next cycle.
- R3: A word whose sequencing code is 2'b00 makes `uaddr` 0 on the next cycle.
- R4: Sequencing code 2'b01 dispatches through table one on `opcode`. 6'h00 goes to 6, 6'h23 and 6'h2B go to 2, 6'h04 goes to 8, and 6'h02 goes to 9.
- R5: Sequencing code 2'b10 dispatches through table two on `opcode`. 6'h23 goes to 3 and 6'h2B goes to 5.
- R6: An opcode that the active table does not map sends `uaddr` to 0.
- R7: `alu_fn` is 2'b00 for add, 2'b01 for subtract in the branch compare and 2'b10 for function-code decode. `opa_sel` 0 picks PC and 1 picks register A. `opb_sel` picks register B (00), constant 4 (01), the extended immediate (10) or the shifted immediate (11).
- R8: A register write of ALUOut drives `rf_we`=1, `rf_dst_rd`=1 and `rf_from_mem`=0. A write of MDR drives `rf_we`=1, `rf_dst_rd`=0 and `rf_from_mem`=1.
- R9: A PC-addressed read drives `mem_rd`=1, `addr_from_alu`=0 and `ir_load`=1. An ALUOut-addressed read drives `mem_rd`=1 and `addr_from_alu`=1. A store drives `mem_wr`=1 and `addr_from_alu`=1. `mem_rd` and `mem_wr` are never high together.
- R10: `pc_sel` is 00 for the ALU result with `pc_we_uncond`, 01 for ALUOut with `pc_we_zero`, and 10 for the jump target with `pc_we_uncond`. `pc_load` equals `pc_we_uncond` OR (`pc_we_zero` AND `alu_zero`), in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the current instruction |
| alu_zero | input | 1 | ALU zero flag |
| uaddr | output | 4 | Current microaddress |
| alu_fn | output | 2 | ALU function code |
| opa_sel | output | 1 | First ALU operand select |
| opb_sel | output | 2 | Second ALU operand select |
| rf_we | output | 1 | Register-file write enable |
| rf_dst_rd | output | 1 | Destination from rd field (1) or rt field (0) |
| rf_from_mem | output | 1 | Write data from MDR (1) or ALUOut (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register load |
| addr_from_alu | output | 1 | Memory address from ALUOut (1) or PC (0) |
| pc_sel | output | 2 | PC source select |
| pc_we_uncond | output | 1 | Unconditional PC write |
| pc_we_zero | output | 1 | PC write gated by zero |
| pc_load | output | 1 | Effective PC load enable |

## Verification
On every cycle the assertions check the following. A step, fetch-return or table-one dispatch lands on the address the sequencing code demands. Memory read and write never coincide. A register write always pairs its destination field with its data source. A conditional PC write always selects ALUOut, and with both PC write flags low `pc_load` stays low. Only the bench scenarios show the full microinstruction paths: the exact control vector of every word, the table-two split between loads and stores, unmapped opcodes falling back to fetch, and the branch load following the zero flag in the same cycle.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

    typedef enum logic [1:0] {
        SEQ_FETCH = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_RSV  = 2'b11
    } alu_e;

    typedef enum logic {
        OPA_PC   = 1'b0,
        OPA_REGA = 1'b1
    } opa_e;

    typedef enum logic [1:0] {
        OPB_REGB  = 2'b00,
        OPB_FOUR  = 2'b01,
        OPB_IMM   = 2'b10,
        OPB_IMMSH = 2'b11
    } opb_e;

    typedef enum logic [1:0] {
        RF_NONE     = 2'b00,
        RF_FROM_ALU = 2'b01,
        RF_FROM_MDR = 2'b10
    } rfc_e;

    typedef enum logic [1:0] {
        MEM_NONE   = 2'b00,
        MEM_RD_PC  = 2'b01,
        MEM_RD_ALU = 2'b10,
        MEM_WR_ALU = 2'b11
    } memc_e;

    typedef enum logic [1:0] {
        PC_NONE = 2'b00,
        PC_ALU  = 2'b01,
        PC_COND = 2'b10,
        PC_JUMP = 2'b11
    } pcc_e;

    // Symbolic microinstruction as held in the store
    typedef struct packed {
        alu_e  alu;
        opa_e  opa;
        opb_e  opb;
        rfc_e  rf;
        memc_e mem;
        pcc_e  pc;
        seq_e  seq;
    } uinstr_t;

    // Expanded datapath control lines
    typedef struct packed {
        logic [1:0] alu_fn;
        logic       opa_sel;
        logic [1:0] opb_sel;
        logic       rf_we;
        logic       rf_dst_rd;
        logic       rf_from_mem;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_load;
        logic       addr_from_alu;
        logic [1:0] pc_sel;
        logic       pc_we_uncond;
        logic       pc_we_zero;
        logic       pc_load;
    } ctrl_t;

    // Microprogram entry points
    localparam int UA_FETCH  = 0;
    localparam int UA_DECODE = 1;
    localparam int UA_AGEN   = 2;
    localparam int UA_LDMEM  = 3;
    localparam int UA_LDWB   = 4;
    localparam int UA_STMEM  = 5;
    localparam int UA_REXEC  = 6;
    localparam int UA_RWB    = 7;
    localparam int UA_BRCMP  = 8;
    localparam int UA_JUMP   = 9;

    // Instruction class opcodes
    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_BRZ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store
    import useq_pkg::*;
#(
    parameter int UADDR_W = 4
) (
    input  logic [UADDR_W-1:0] uaddr,
    output uinstr_t            uword
);
    localparam int DEPTH = 1 << UADDR_W;

    function automatic uinstr_t word_at(input int a);
        uinstr_t w;
        w = '{alu: ALU_ADD, opa: OPA_PC, opb: OPB_REGB, rf: RF_NONE,
              mem: MEM_NONE, pc: PC_NONE, seq: SEQ_FETCH};
        case (a)
            UA_FETCH: begin
                w.opb = OPB_FOUR;
                w.mem = MEM_RD_PC;
                w.pc  = PC_ALU;
                w.seq = SEQ_NEXT;
            end
            UA_DECODE: begin
                w.opb = OPB_IMMSH;
                w.seq = SEQ_DISP1;
            end
            UA_AGEN: begin
                w.opa = OPA_REGA;
                w.opb = OPB_IMM;
                w.seq = SEQ_DISP2;
            end
            UA_LDMEM: begin
                w.mem = MEM_RD_ALU;
                w.seq = SEQ_NEXT;
            end
            UA_LDWB:  w.rf  = RF_FROM_MDR;
            UA_STMEM: w.mem = MEM_WR_ALU;
            UA_REXEC: begin
                w.alu = ALU_FUNC;
                w.opa = OPA_REGA;
                w.seq = SEQ_NEXT;
            end
            UA_RWB:   w.rf  = RF_FROM_ALU;
            UA_BRCMP: begin
                w.alu = ALU_SUB;
                w.opa = OPA_REGA;
                w.pc  = PC_COND;
            end
            UA_JUMP:  w.pc  = PC_JUMP;
            default:  ;
        endcase
        return w;
    endfunction

    uinstr_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = word_at(g);
    end

    assign uword = rom[uaddr];

endmodule

// File: rtl/useq_dispatch.sv
`timescale 1ns/1ps
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int UADDR_W = 4,
    parameter int OP_W    = 6
) (
    input  logic [OP_W-1:0]    opcode,
    output logic [UADDR_W-1:0] tgt_one,
    output logic [UADDR_W-1:0] tgt_two
);
    localparam logic [OP_W-1:0] K_REG   = OP_W'(OPC_REG);
    localparam logic [OP_W-1:0] K_JMP   = OP_W'(OPC_JMP);
    localparam logic [OP_W-1:0] K_BRZ   = OP_W'(OPC_BRZ);
    localparam logic [OP_W-1:0] K_LOAD  = OP_W'(OPC_LOAD);
    localparam logic [OP_W-1:0] K_STORE = OP_W'(OPC_STORE);

    // First table: instruction class to first execute step
    always_comb begin
        tgt_one = UADDR_W'(UA_FETCH);
        if (opcode == K_REG)                          tgt_one = UADDR_W'(UA_REXEC);
        else if (opcode == K_LOAD || opcode == K_STORE) tgt_one = UADDR_W'(UA_AGEN);
        else if (opcode == K_BRZ)                     tgt_one = UADDR_W'(UA_BRCMP);
        else if (opcode == K_JMP)                     tgt_one = UADDR_W'(UA_JUMP);
    end

    // Second table: memory access direction
    always_comb begin
        tgt_two = UADDR_W'(UA_FETCH);
        if (opcode == K_LOAD)       tgt_two = UADDR_W'(UA_LDMEM);
        else if (opcode == K_STORE) tgt_two = UADDR_W'(UA_STMEM);
    end

endmodule

// File: rtl/useq_decode.sv
`timescale 1ns/1ps
module useq_decode
    import useq_pkg::*;
(
    input  uinstr_t uword,
    input  logic    alu_zero,
    output ctrl_t   ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_fn  = uword.alu;
        ctrl.opa_sel = uword.opa;
        ctrl.opb_sel = uword.opb;

        case (uword.rf)
            RF_FROM_ALU: begin
                ctrl.rf_we     = 1'b1;
                ctrl.rf_dst_rd = 1'b1;
            end
            RF_FROM_MDR: begin
                ctrl.rf_we       = 1'b1;
                ctrl.rf_from_mem = 1'b1;
            end
            default: ;
        endcase

        case (uword.mem)
            MEM_RD_PC: begin
                ctrl.mem_rd  = 1'b1;
                ctrl.ir_load = 1'b1;
            end
            MEM_RD_ALU: begin
                ctrl.mem_rd        = 1'b1;
                ctrl.addr_from_alu = 1'b1;
            end
            MEM_WR_ALU: begin
                ctrl.mem_wr        = 1'b1;
                ctrl.addr_from_alu = 1'b1;
            end
            default: ;
        endcase

        case (uword.pc)
            PC_ALU: begin
                ctrl.pc_sel       = 2'b00;
                ctrl.pc_we_uncond = 1'b1;
            end
            PC_COND: begin
                ctrl.pc_sel     = 2'b01;
                ctrl.pc_we_zero = 1'b1;
            end
            PC_JUMP: begin
                ctrl.pc_sel       = 2'b10;
                ctrl.pc_we_uncond = 1'b1;
            end
            default: ;
        endcase

        ctrl.pc_load = ctrl.pc_we_uncond | (ctrl.pc_we_zero & alu_zero);
    end

endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int UADDR_W = 4,
    parameter int OP_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_zero,
    output logic [UADDR_W-1:0] uaddr,
    output logic [1:0]         alu_fn,
    output logic               opa_sel,
    output logic [1:0]         opb_sel,
    output logic               rf_we,
    output logic               rf_dst_rd,
    output logic               rf_from_mem,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               ir_load,
    output logic               addr_from_alu,
    output logic [1:0]         pc_sel,
    output logic               pc_we_uncond,
    output logic               pc_we_zero,
    output logic               pc_load
);
    typedef struct packed {
        logic [UADDR_W-1:0] upc;
    } state_t;

    state_t             st_d, st_q;
    uinstr_t            uword;
    ctrl_t              ctrl;
    logic [UADDR_W-1:0] tgt_one, tgt_two;

    useq_store #(.UADDR_W(UADDR_W)) u_store (
        .uaddr (st_q.upc),
        .uword (uword)
    );

    useq_dispatch #(.UADDR_W(UADDR_W), .OP_W(OP_W)) u_dispatch (
        .opcode  (opcode),
        .tgt_one (tgt_one),
        .tgt_two (tgt_two)
    );

    useq_decode u_decode (
        .uword    (uword),
        .alu_zero (alu_zero),
        .ctrl     (ctrl)
    );

    // Next microaddress selection
    always_comb begin
        st_d = st_q;
        case (uword.seq)
            SEQ_NEXT:  st_d.upc = st_q.upc + 1'b1;
            SEQ_DISP1: st_d.upc = tgt_one;
            SEQ_DISP2: st_d.upc = tgt_two;
            default:   st_d.upc = UADDR_W'(UA_FETCH);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{upc: UADDR_W'(UA_FETCH)};
        else        st_q <= st_d;
    end

    assign uaddr         = st_q.upc;
    assign alu_fn        = ctrl.alu_fn;
    assign opa_sel       = ctrl.opa_sel;
    assign opb_sel       = ctrl.opb_sel;
    assign rf_we         = ctrl.rf_we;
    assign rf_dst_rd     = ctrl.rf_dst_rd;
    assign rf_from_mem   = ctrl.rf_from_mem;
    assign mem_rd        = ctrl.mem_rd;
    assign mem_wr        = ctrl.mem_wr;
    assign ir_load       = ctrl.ir_load;
    assign addr_from_alu = ctrl.addr_from_alu;
    assign pc_sel        = ctrl.pc_sel;
    assign pc_we_uncond  = ctrl.pc_we_uncond;
    assign pc_we_zero    = ctrl.pc_we_zero;
    assign pc_load       = ctrl.pc_load;

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uword.seq == SEQ_NEXT) |=> (uaddr == UADDR_W'($past(uaddr) + 1'b1)));

    // R3
    fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uword.seq == SEQ_FETCH) |=> (uaddr == '0));

    // R4
    disp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uword.seq == SEQ_DISP1) |=> (uaddr == $past(tgt_one)));

    // R9
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    rf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_dst_rd != rf_from_mem));

    // R10
    pc_cond_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_zero |-> (pc_sel == 2'b01));

    // R10
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we_uncond && !pc_we_zero) |-> !pc_load);

endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/1ps
module useq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic [3:0] uaddr;
    logic [1:0] alu_fn, opb_sel, pc_sel;
    logic       opa_sel, rf_we, rf_dst_rd, rf_from_mem, mem_rd, mem_wr;
    logic       ir_load, addr_from_alu, pc_we_uncond, pc_we_zero, pc_load;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    useq_ctrl u_useq_ctrl (
        .clk (clk), .rst_n (rst_n), .opcode (opcode), .alu_zero (alu_zero),
        .uaddr (uaddr), .alu_fn (alu_fn), .opa_sel (opa_sel), .opb_sel (opb_sel),
        .rf_we (rf_we), .rf_dst_rd (rf_dst_rd), .rf_from_mem (rf_from_mem),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .ir_load (ir_load),
        .addr_from_alu (addr_from_alu), .pc_sel (pc_sel),
        .pc_we_uncond (pc_we_uncond), .pc_we_zero (pc_we_zero), .pc_load (pc_load)
    );

    // {alu_fn, opa, opb, rf_we, dst_rd, from_mem, rd, wr, ir, from_alu, pc_sel, we_u, we_z, load}
    wire [16:0] cvec = {alu_fn, opa_sel, opb_sel, rf_we, rf_dst_rd, rf_from_mem,
                        mem_rd, mem_wr, ir_load, addr_from_alu, pc_sel,
                        pc_we_uncond, pc_we_zero, pc_load};

    localparam logic [16:0] C_FET = 17'b00_0_01_000_1_0_1_0_00_1_0_1;
    localparam logic [16:0] C_DEC = 17'b00_0_11_000_0_0_0_0_00_0_0_0;
    localparam logic [16:0] C_AGN = 17'b00_1_10_000_0_0_0_0_00_0_0_0;
    localparam logic [16:0] C_LDM = 17'b00_0_00_000_1_0_0_1_00_0_0_0;
    localparam logic [16:0] C_LWB = 17'b00_0_00_101_0_0_0_0_00_0_0_0;
    localparam logic [16:0] C_STM = 17'b00_0_00_000_0_1_0_1_00_0_0_0;
    localparam logic [16:0] C_RUN = 17'b10_1_00_000_0_0_0_0_00_0_0_0;
    localparam logic [16:0] C_RWB = 17'b00_0_00_110_0_0_0_0_00_0_0_0;
    localparam logic [16:0] C_BR0 = 17'b01_1_00_000_0_0_0_0_01_0_1_0;
    localparam logic [16:0] C_BR1 = 17'b01_1_00_000_0_0_0_0_01_0_1_1;
    localparam logic [16:0] C_JMP = 17'b00_0_00_000_0_0_0_0_10_1_0_1;

    typedef struct packed {
        logic [5:0]  op;
        logic        z;
        logic [3:0]  ua;
        logic [16:0] c;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // load path (R2, R4, R5, R8, R9)
        '{6'h23, 1'b0, 4'd0, C_FET}, '{6'h23, 1'b0, 4'd1, C_DEC},
        '{6'h23, 1'b0, 4'd2, C_AGN}, '{6'h23, 1'b0, 4'd3, C_LDM},
        '{6'h23, 1'b0, 4'd4, C_LWB},
        // store path (R3, R5, R9)
        '{6'h2B, 1'b1, 4'd0, C_FET}, '{6'h2B, 1'b0, 4'd1, C_DEC},
        '{6'h2B, 1'b0, 4'd2, C_AGN}, '{6'h2B, 1'b0, 4'd5, C_STM},
        // register op (R4, R7, R8)
        '{6'h00, 1'b0, 4'd0, C_FET}, '{6'h00, 1'b0, 4'd1, C_DEC},
        '{6'h00, 1'b0, 4'd6, C_RUN}, '{6'h00, 1'b0, 4'd7, C_RWB},
        // branch taken and not taken (R7, R10)
        '{6'h04, 1'b0, 4'd0, C_FET}, '{6'h04, 1'b0, 4'd1, C_DEC},
        '{6'h04, 1'b1, 4'd8, C_BR1},
        '{6'h04, 1'b0, 4'd0, C_FET}, '{6'h04, 1'b0, 4'd1, C_DEC},
        '{6'h04, 1'b0, 4'd8, C_BR0},
        // jump, zero high has no effect (R10)
        '{6'h02, 1'b1, 4'd0, C_FET}, '{6'h02, 1'b1, 4'd1, C_DEC},
        '{6'h02, 1'b1, 4'd9, C_JMP},
        // unmapped opcode in table one (R6)
        '{6'h3F, 1'b0, 4'd0, C_FET}, '{6'h3F, 1'b0, 4'd1, C_DEC},
        '{6'h3F, 1'b0, 4'd0, C_FET}, '{6'h3F, 1'b0, 4'd1, C_DEC}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step();
        step();
        #1;
        check("R1 reset uaddr", 32'(uaddr), 32'd0);
        check("R1 reset ctrl", 32'(cvec), 32'(C_FET));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            opcode   = VECS[i].op;
            alu_zero = VECS[i].z;
            #1;
            check("R2 R4 R5 uaddr", 32'(uaddr), 32'(VECS[i].ua));
            check("R7 R8 R9 R10 ctrl", 32'(cvec), 32'(VECS[i].c));
            step();
        end

        // R6: register-op opcode reaching table two falls back to fetch
        opcode = 6'h23;
        step();
        step();
        #1;
        check("R5 agen reached", 32'(uaddr), 32'd2);
        opcode = 6'h00;
        step();
        #1;
        check("R6 table two unmapped", 32'(uaddr), 32'd0);

        // R10: pc_load follows zero within the same cycle
        opcode = 6'h04;
        step();
        step();
        alu_zero = 1'b0;
        #1;
        check("R10 branch no zero", 32'(pc_load), 32'd0);
        alu_zero = 1'b1;
        #1;
        check("R10 branch zero", 32'(pc_load), 32'd1);
        check("R10 branch select", 32'(pc_sel), 32'd1);
        step();
        #1;
        check("R3 after branch", 32'(uaddr), 32'd0);

        // R1: reset in mid-sequence returns to fetch
        opcode = 6'h23;
        step();
        step();
        #1;
        check("R1 mid path", 32'(uaddr), 32'd2);
        rst_n = 1'b0;
        step();
        #1;
        check("R1 reset mid path", 32'(uaddr), 32'd0);
        rst_n = 1'b1;
        step();
        #1;
        check("R1 released", 32'(uaddr), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule